// File: doc/BRIEF.md
# Multi-Bank Level Interrupt Controller

This block gathers level-sensitive interrupt sources into a set of banks of 32 lines each and routes them onto three processor-facing lines: a normal interrupt request, a fast interrupt request and an endpoint line. Every bank exposes a read-only word with the live source levels. Each bank also has three independent enable words, one per output path, so the same source can be sent to any mix of the three lines.

The bank count is a build-time parameter. Bank `n` sits in a 16-byte window at byte offset `n*16`, and source `bank*32 + bit` is global source number `bank*32 + bit`. A helper window placed just after the last bank reports, for each path, the highest-numbered source that is both pending and enabled. Software can therefore service sources from the top down without scanning every bank.

Access uses a simple register bus. It has an address-valid strobe, separate write and read enables, and read data that is registered one cycle after the strobe.

Top module: `mbank_intc`

## Requirements
- R1: After reset all enable words are zero, the three outputs are low and the read data bus is zero.
- R2: Reading slot 0x0 of a bank window returns the present level of that bank's 32 sources, whatever the enable words hold.
- R3: Slots 0x4, 0x8 and 0xC of a bank window are read/write enable words for the request, fast and endpoint paths. Each word is kept independently and reads back what was last written.
- R4: `irq_o` is high exactly when, in some bank, a source is high and its bit in the request enable word is 1. A 0 bit blocks that source.
- R5: `fiq_o` and `ep_o` are formed the same way as `irq_o`, using the fast and endpoint enable words respectively.
- R6: Sources are levels with no capture. Once an enabled source drops and no other enabled source is high, the output drops in the same cycle.
- R7: Writes to a source-level slot (offset 0x0) change no state: enable words and later level reads are unaffected.
- R8: Bank `n` occupies byte offsets `n*16` to `n*16+15`, and its bit `b` is global source number `n*32+b`.
- R9: The helper window starts at byte offset `NUM_BANKS*16`. Slot 0x0 there returns the request path's highest pending enabled global source number in the low bits, with bit 31 set. It returns 0 when nothing is pending.
- R10: Helper slots 0x4 and 0x8 give the same encoding for the fast path and the endpoint path.
- R11: Read data is updated on the first clock edge after a strobe with read enable and is then held until the next such read. Slot 0xC of the helper window, windows past the helper, and addresses with bits [1:0] nonzero all read as 0. Writes to any of these addresses are ignored.
- R12: A write or read enable with the address strobe low changes no enable word and no read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NUM_BANKS*32 | Level interrupt sources, bit index = global source number |
| bus_sel | input | 1 | Address valid strobe |
| bus_wr | input | 1 | Write enable, qualified by bus_sel |
| bus_rd | input | 1 | Read enable, qualified by bus_sel |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Combined request line |
| fiq_o | output | 1 | Combined fast interrupt line |
| ep_o | output | 1 | Combined endpoint line |

## Verification
The embedded properties assume that the bus never raises write and read enables together, and that the address is wide enough to reach the helper window. The bench keeps to this: each access is either a read or a write, and it targets only the windows of a two-bank build. The properties also assume that sources move only between clock edges. The bench changes `src_i` and all bus signals only on the falling edge, so every level the design samples is settled half a period before the rising edge that uses it.

// File: rtl/mbank_intc_pkg.sv
package mbank_intc_pkg;

  localparam int unsigned BANK_SRC = 32;
  localparam int unsigned DATA_W   = 32;

  // Slot select within a 16-byte bank window, taken from address bits [3:2].
  typedef enum logic [1:0] {
    SLOT_LEVEL = 2'd0,
    SLOT_REQ   = 2'd1,
    SLOT_FAST  = 2'd2,
    SLOT_ENDP  = 2'd3
  } slot_e;

  typedef struct packed {
    logic endp;
    logic fast;
    logic req;
  } path_we_t;

  typedef struct packed {
    logic [BANK_SRC-1:0] endp;
    logic [BANK_SRC-1:0] fast;
    logic [BANK_SRC-1:0] req;
  } en_set_t;

endpackage

// File: rtl/mbank_intc_rstsync.sv
module mbank_intc_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_q_n = stage_q[1];

endmodule

// File: rtl/mbank_intc_prio.sv
module mbank_intc_prio #(
  parameter int unsigned WIDTH = 64,
  localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] vec,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);

  // Upward scan: the last set bit seen is the most significant one.
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (vec[i]) begin
        valid = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  AST_IDX_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> vec[idx]); // R9

  AST_NONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (vec == '0) |-> !valid); // R9

endmodule

// File: rtl/mbank_intc_bank.sv
module mbank_intc_bank
  import mbank_intc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  path_we_t            we,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [BANK_SRC-1:0] src,
  output en_set_t             en,
  output logic [BANK_SRC-1:0] hit_req,
  output logic [BANK_SRC-1:0] hit_fast,
  output logic [BANK_SRC-1:0] hit_endp
);

  en_set_t en_q;
  en_set_t en_d;

  always_comb begin
    en_d = en_q;
    if (we.req) begin
      en_d.req = wdata[BANK_SRC-1:0];
    end
    if (we.fast) begin
      en_d.fast = wdata[BANK_SRC-1:0];
    end
    if (we.endp) begin
      en_d.endp = wdata[BANK_SRC-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (we.req || we.fast || we.endp) begin
      en_q <= en_d;
    end
  end

  assign en       = en_q;
  assign hit_req  = src & en_q.req;
  assign hit_fast = src & en_q.fast;
  assign hit_endp = src & en_q.endp;

  AST_EN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(we.req || we.fast || we.endp) |=> $stable(en_q)); // R12

  AST_PATH_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
    !we.fast |=> $stable(en_q.fast)); // R3

endmodule

// File: rtl/mbank_intc_bus.sv
module mbank_intc_bus
  import mbank_intc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 8,
  localparam int unsigned WIN_W    = ADDR_W - 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                sel,
  input  logic                                wr,
  input  logic                                rd,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [DATA_W-1:0]                   wdata_unused_guard,
  input  logic [NUM_BANKS-1:0][BANK_SRC-1:0]  level,
  input  en_set_t [NUM_BANKS-1:0]             en,
  input  logic [DATA_W-1:0]                   hlp_req,
  input  logic [DATA_W-1:0]                   hlp_fast,
  input  logic [DATA_W-1:0]                   hlp_endp,
  output path_we_t [NUM_BANKS-1:0]            we,
  output logic [DATA_W-1:0]                   rdata
);

  logic [WIN_W-1:0]  win;
  slot_e             slot;
  logic              aligned;
  logic              rd_en;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rdata_d;
  logic              guard_nz;

  assign win      = addr[ADDR_W-1:4];
  assign slot     = slot_e'(addr[3:2]);
  assign aligned  = (addr[1:0] == 2'b00);
  assign rd_en    = sel && rd && aligned;
  assign guard_nz = |wdata_unused_guard;

  // Write strobes, one per path per bank.
  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      logic hit;
      hit = sel && wr && aligned && (win == WIN_W'(b));
      we[b].req  = hit && (slot == SLOT_REQ);
      we[b].fast = hit && (slot == SLOT_FAST);
      we[b].endp = hit && (slot == SLOT_ENDP);
    end
  end

  // Read selection.
  always_comb begin
    rd_val = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (win == WIN_W'(b)) begin
        case (slot)
          SLOT_LEVEL: rd_val = level[b];
          SLOT_REQ:   rd_val = en[b].req;
          SLOT_FAST:  rd_val = en[b].fast;
          SLOT_ENDP:  rd_val = en[b].endp;
          default:    rd_val = '0;
        endcase
      end
    end
    if (win == WIN_W'(NUM_BANKS)) begin
      case (slot)
        SLOT_LEVEL: rd_val = hlp_req;
        SLOT_REQ:   rd_val = hlp_fast;
        SLOT_FAST:  rd_val = hlp_endp;
        default:    rd_val = '0;
      endcase
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (sel && rd) begin
      rdata_d = aligned ? rd_val : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (sel && rd) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && rd) |=> $stable(rdata)); // R11

  AST_NO_WE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (we == '0)); // R12

  AST_MISALIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && rd && !aligned && !guard_nz) |=> (rdata == '0)); // R11

endmodule

// File: rtl/mbank_intc.sv
module mbank_intc
  import mbank_intc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 8,
  localparam int unsigned NUM_SRC  = NUM_BANKS * BANK_SRC,
  localparam int unsigned IDX_W    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_o,
  output logic               fiq_o,
  output logic               ep_o
);

  logic                               rst_q_n;
  path_we_t [NUM_BANKS-1:0]           we;
  en_set_t  [NUM_BANKS-1:0]           en;
  logic [NUM_BANKS-1:0][BANK_SRC-1:0] level;
  logic [NUM_SRC-1:0]                 hit_req;
  logic [NUM_SRC-1:0]                 hit_fast;
  logic [NUM_SRC-1:0]                 hit_endp;
  logic                               v_req;
  logic                               v_fast;
  logic                               v_endp;
  logic [IDX_W-1:0]                   i_req;
  logic [IDX_W-1:0]                   i_fast;
  logic [IDX_W-1:0]                   i_endp;
  logic [DATA_W-1:0]                  hlp_req;
  logic [DATA_W-1:0]                  hlp_fast;
  logic [DATA_W-1:0]                  hlp_endp;

  mbank_intc_rstsync u_rstsync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign level[g] = src_i[g*BANK_SRC +: BANK_SRC];

    mbank_intc_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .we       (we[g]),
      .wdata    (bus_wdata),
      .src      (src_i[g*BANK_SRC +: BANK_SRC]),
      .en       (en[g]),
      .hit_req  (hit_req[g*BANK_SRC +: BANK_SRC]),
      .hit_fast (hit_fast[g*BANK_SRC +: BANK_SRC]),
      .hit_endp (hit_endp[g*BANK_SRC +: BANK_SRC])
    );
  end

  assign irq_o = |hit_req;
  assign fiq_o = |hit_fast;
  assign ep_o  = |hit_endp;

  mbank_intc_prio #(.WIDTH(NUM_SRC)) u_prio_req (
    .clk (clk), .rst_n (rst_q_n), .vec (hit_req),  .valid (v_req),  .idx (i_req)
  );
  mbank_intc_prio #(.WIDTH(NUM_SRC)) u_prio_fast (
    .clk (clk), .rst_n (rst_q_n), .vec (hit_fast), .valid (v_fast), .idx (i_fast)
  );
  mbank_intc_prio #(.WIDTH(NUM_SRC)) u_prio_endp (
    .clk (clk), .rst_n (rst_q_n), .vec (hit_endp), .valid (v_endp), .idx (i_endp)
  );

  assign hlp_req  = {v_req,  {(DATA_W-1-IDX_W){1'b0}}, i_req};
  assign hlp_fast = {v_fast, {(DATA_W-1-IDX_W){1'b0}}, i_fast};
  assign hlp_endp = {v_endp, {(DATA_W-1-IDX_W){1'b0}}, i_endp};

  mbank_intc_bus #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_bus (
    .clk                (clk),
    .rst_n              (rst_q_n),
    .sel                (bus_sel),
    .wr                 (bus_wr),
    .rd                 (bus_rd),
    .addr               (bus_addr),
    .wdata_unused_guard (bus_wdata & {DATA_W{bus_wr && bus_rd}}),
    .level              (level),
    .en                 (en),
    .hlp_req            (hlp_req),
    .hlp_fast           (hlp_fast),
    .hlp_endp           (hlp_endp),
    .we                 (we),
    .rdata              (bus_rdata)
  );

  AST_REQ_HELPER: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq_o == v_req); // R9

  AST_FAST_HELPER: assert property (@(posedge clk) disable iff (!rst_q_n)
    fiq_o == v_fast); // R10

  AST_LEVEL_WR_KEEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_sel && bus_wr && (bus_addr[3:0] == 4'h0)) |=> $stable(en)); // R7

  AST_NO_EN_QUIET: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en == '0) |-> !(irq_o || fiq_o || ep_o)); // R4

endmodule

// File: tb/mbank_intc_bench.sv
`timescale 1ns/1ps
module mbank_intc_bench;

  localparam int NB = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] src_i;
  logic        bus_sel, bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o, ep_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  bit rd_seen = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  mbank_intc #(.NUM_BANKS(NB), .ADDR_W(8)) u_mbank_intc (
    .clk (clk), .rst_n (rst_n), .src_i (src_i),
    .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_rd (bus_rd),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .irq_o (irq_o), .fiq_o (fiq_o), .ep_o (ep_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares each read result the cycle after its strobe.
  always @(posedge clk) rd_seen <= bus_sel & bus_rd;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    #1;
  endtask

  task automatic bus_read(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
    #1;
  endtask

  task automatic outs(logic [2:0] exp, string tag);
    #1;
    check(tag, {29'd0, irq_o, fiq_o, ep_o}, {29'd0, exp});
  endtask

  task automatic set_src(logic [31:0] b1, logic [31:0] b0);
    @(negedge clk);
    src_i = {b1, b0};
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    rst_n = 1'b0; src_i = '0;
    bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    outs(3'b000, "R1 outputs idle after reset");
    check("R1 rdata zero after reset", bus_rdata, 32'h0);
    bus_read(8'h04, 32'h0, "R1 req enable bank0 reset");
    bus_read(8'h18, 32'h0, "R1 fast enable bank1 reset");

    set_src(32'h0000_8000, 32'hA5A5_0001);
    outs(3'b000, "R4 masked sources give no output");
    bus_read(8'h00, 32'hA5A5_0001, "R2 level bank0");
    bus_read(8'h10, 32'h0000_8000, "R2 R8 level bank1");

    bus_write(8'h04, 32'h0000_0001);
    outs(3'b100, "R4 req enable bit0 bank0");
    bus_read(8'h20, 32'h8000_0000, "R9 helper req idx0");
    bus_read(8'h24, 32'h0, "R10 helper fast none");

    bus_write(8'h14, 32'hFFFF_FFFF);
    bus_read(8'h20, 32'h8000_002F, "R9 R8 helper req idx47");

    bus_write(8'h08, 32'h8000_0000);
    outs(3'b110, "R5 fast path bit31");
    bus_read(8'h24, 32'h8000_001F, "R10 helper fast idx31");
    bus_read(8'h28, 32'h0, "R10 helper endp none");

    bus_write(8'h1C, 32'h0000_4000);
    outs(3'b110, "R5 endp enabled on low source");
    set_src(32'h0000_4000, 32'hA5A5_0001);
    outs(3'b111, "R5 endp fires");
    bus_read(8'h28, 32'h8000_002E, "R10 helper endp idx46");
    bus_read(8'h20, 32'h8000_002E, "R9 helper req idx46");
    set_src(32'h0, 32'hA5A5_0001);
    outs(3'b110, "R6 endp drops with source");
    bus_read(8'h20, 32'h8000_0000, "R6 R9 helper req back to idx0");

    bus_read(8'h04, 32'h0000_0001, "R3 req bank0 readback");
    bus_read(8'h08, 32'h8000_0000, "R3 fast bank0 readback");
    bus_read(8'h0C, 32'h0, "R3 endp bank0 untouched");
    bus_read(8'h14, 32'hFFFF_FFFF, "R3 req bank1 readback");
    bus_read(8'h18, 32'h0, "R3 fast bank1 untouched");
    bus_read(8'h1C, 32'h0000_4000, "R3 endp bank1 readback");

    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_read(8'h00, 32'hA5A5_0001, "R7 level unchanged by write");
    bus_read(8'h04, 32'h0000_0001, "R7 enable unchanged by level write");
    outs(3'b110, "R7 outputs unchanged");

    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h0;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_read(8'h04, 32'h0000_0001, "R12 write without strobe ignored");

    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 8'h08;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R11 R12 rdata held without strobe", bus_rdata, 32'h0000_0001);

    bus_read(8'h2C, 32'h0, "R11 helper slot C reads zero");
    bus_read(8'h30, 32'h0, "R11 past helper reads zero");
    bus_read(8'h05, 32'h0, "R11 misaligned reads zero");
    bus_write(8'h05, 32'h0);
    bus_read(8'h04, 32'h0000_0001, "R11 misaligned write ignored");

    bus_write(8'h04, 32'h0);
    bus_write(8'h14, 32'h0);
    outs(3'b010, "R4 req cleared");
    bus_read(8'h20, 32'h0, "R9 helper req none");

    set_src(32'h0, 32'h0);
    outs(3'b000, "R6 all sources low");

    repeat (3) @(negedge clk);
    check("scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule